// File: doc/BRIEF.md
# Relative Countdown Alarm

This block is a relative alarm timer. Software loads a countdown made of days, hours, minutes and seconds. While counting is switched on, every one-second tick pulse takes one second off that value. A borrow ripples from each field into the next one up. When the value steps down to all zeros, a sticky pending flag is set and the count stays at zero. The pending flag drives a level interrupt when the interrupt route is enabled. Software clears the flag by writing a one to it.

Access is through a simple single-cycle register port. A write strobe with a 2-bit word address and 32-bit data updates a register on the clock edge. The read data is a combinational view of the register that the same address selects. The day field is `DAY_W` bits wide, 8 by default, which gives 0 to 255 days.

Top module: `alarm_countdown`

## Requirements
- R1: After reset the count, the run enable, the interrupt enable and the pending flag are all zero, every register reads zero and `irq` is low.
- R2: The count register sits at address 0. Seconds are in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days in bits 28:21 (with `DAY_W`=8). Writes store those fields, and every other bit reads as zero.
- R3: With counting on and a nonzero count, each cycle with `sec_tick` high lowers the seconds field by one. Cycles without a tick leave the count unchanged.
- R4: A tick when the seconds field is 0 and the count is nonzero reloads seconds with 59 and lowers the minutes by one.
- R5: A borrow when minutes are 0 reloads minutes with 59 and lowers the hours. A borrow when hours are 0 reloads hours with 23 and lowers the days.
- R6: Bit 0 of address 1 is the run enable. While it is 0, ticks change neither the count nor the pending flag.
- R7: The tick that takes a nonzero count to all zeros sets the pending flag. After that the count stays at zero until it is written. A count that is already zero never sets the flag.
- R8: Bit 0 of address 3 reads the pending flag. Writing 1 there clears the flag, and writing 0 leaves it unchanged.
- R9: Bit 0 of address 2 is the interrupt enable. `irq` is high exactly while both the pending flag and the interrupt enable are set, and it stays high for as long as both hold.
- R10: If a clear write and an expiry fall in the same cycle, the pending flag ends that cycle set.
- R11: A write to the count register in the same cycle as a tick stores the written value. Writing zero cancels a countdown that is running, and no pending flag follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Level interrupt |

## Verification
The embedded assertions check several rules on every cycle. The count holds while counting is off. A zero count stays zero. The pending flag rises only on an enabled tick that leaves the count at zero, and it stays set until a clear write. Each tick takes exactly one off the seconds, or reloads them to 59 on a borrow. The bench scenarios are what show the mixed-radix results across whole day and hour boundaries, the field layout on read-back, and the interrupt gating. They also show two collisions: a clear write against an expiry, and a count write against a tick.

// File: rtl/alarm_countdown.sv
module alarm_countdown #(
  parameter int DAY_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int MIN_LSB = 8;
  localparam int HR_LSB  = 16;
  localparam int DAY_LSB = 21;
  localparam logic [1:0] A_COUNT = 2'd0;
  localparam logic [1:0] A_RUN   = 2'd1;
  localparam logic [1:0] A_IEN   = 2'd2;
  localparam logic [1:0] A_STAT  = 2'd3;

  logic [5:0] sec, mins, n_sec, n_min;
  logic [4:0] hr, n_hr;
  logic [DAY_W-1:0] day, n_day;
  logic run_en, irq_en, pend;
  logic [31:0] cnt_word;

  wire unused_wdata = ^wdata;
  wire wr_cnt   = wr_en && addr == A_COUNT;
  wire clr_pend = wr_en && addr == A_STAT && wdata[0];
  wire cnt_nz   = |{day, hr, mins, sec};
  wire step     = sec_tick && run_en && cnt_nz && !wr_cnt;
  wire expire   = step && ({n_day, n_hr, n_min, n_sec} == '0);

  always_comb begin
    n_sec = sec; n_min = mins; n_hr = hr; n_day = day;
    if (sec != 6'd0) n_sec = sec - 6'd1;
    else begin
      n_sec = 6'd59;
      if (mins != 6'd0) n_min = mins - 6'd1;
      else begin
        n_min = 6'd59;
        if (hr != 5'd0) n_hr = hr - 5'd1;
        else begin
          n_hr  = 5'd23;
          n_day = day - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= '0; mins <= '0; hr <= '0; day <= '0;
    end else if (wr_cnt) begin
      sec  <= wdata[5:0];
      mins <= wdata[MIN_LSB +: 6];
      hr   <= wdata[HR_LSB +: 5];
      day  <= wdata[DAY_LSB +: DAY_W];
    end else if (step) begin
      sec <= n_sec; mins <= n_min; hr <= n_hr; day <= n_day;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0; irq_en <= 1'b0; pend <= 1'b0;
    end else begin
      if (wr_en && addr == A_RUN) run_en <= wdata[0];
      if (wr_en && addr == A_IEN) irq_en <= wdata[0];
      if (expire)        pend <= 1'b1;
      else if (clr_pend) pend <= 1'b0;
    end
  end

  always_comb begin
    cnt_word = '0;
    cnt_word[5:0]              = sec;
    cnt_word[MIN_LSB +: 6]     = mins;
    cnt_word[HR_LSB +: 5]      = hr;
    cnt_word[DAY_LSB +: DAY_W] = day;
  end

  always_comb begin
    case (addr)
      A_COUNT: rdata = cnt_word;
      A_RUN:   rdata = {31'd0, run_en};
      A_IEN:   rdata = {31'd0, irq_en};
      default: rdata = {31'd0, pend};
    endcase
  end

  assign irq = pend & irq_en;

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && run_en && !wr_cnt && sec != 6'd0) |=> (sec == $past(sec) - 6'd1)); // R3
  AST_SEC_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && run_en && !wr_cnt && cnt_nz && sec == 6'd0) |=> (sec == 6'd59)); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_cnt) |=> $stable(cnt_word)); // R6
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_nz && !wr_cnt) |=> !cnt_nz); // R7
  AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> (!cnt_nz && $past(run_en) && $past(sec_tick))); // R7
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_pend) |=> pend); // R8
endmodule

// File: tb/alarm_countdown_tb.sv
module alarm_countdown_tb;
  logic clk = 0, rst_n = 0, sec_tick = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  alarm_countdown u_dut (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  localparam int NV = 6;
  localparam logic [31:0] V_START [NV] = '{32'h5, 32'h100, 32'h10000, 32'h200000, 32'h400001, 32'h1FF73B3B};
  localparam int          V_TICKS [NV] = '{3, 1, 1, 1, 2, 60};
  localparam logic [31:0] V_EXP   [NV] = '{32'h2, 32'h3B, 32'h3B3B, 32'h173B3B, 32'h373B3B, 32'h1FF73A3B};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); check("R1 reset register", v, 32'h0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R2 field layout
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, v); check("R2 all-ones layout", v, 32'h1FFF3F3F);
    wr(2'd0, 32'h0AB2_1C2D);
    rd(2'd0, v); check("R2 pattern layout", v, 32'h0AB2_1C2D & 32'h1FFF3F3F);

    // R3 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, 0);
      wr(2'd0, V_START[i]);
      wr(2'd1, 1);
      ticks(V_TICKS[i]);
      rd(2'd0, v); check($sformatf("R3/R4/R5 vector %0d", i), v, V_EXP[i]);
    end

    // R6 run enable off
    wr(2'd1, 0);
    wr(2'd0, 32'h5);
    ticks(3);
    rd(2'd0, v); check("R6 hold while off", v, 32'h5);
    rd(2'd3, v); check("R6 no pending while off", v, 32'h0);

    // R3 no tick, no change
    wr(2'd1, 1);
    repeat (5) @(negedge clk);
    rd(2'd0, v); check("R3 no tick no change", v, 32'h5);

    // R7 expiry, R9 gating
    wr(2'd0, 32'h2);
    ticks(2);
    rd(2'd0, v); check("R7 reached zero", v, 32'h0);
    rd(2'd3, v); check("R7 pending set", v, 32'h1);
    check("R9 irq masked", {31'd0, irq}, 32'h0);
    wr(2'd2, 1);
    check("R9 irq asserted", {31'd0, irq}, 32'h1);
    repeat (4) @(negedge clk);
    check("R9 irq level held", {31'd0, irq}, 32'h1);
    ticks(3);
    rd(2'd0, v); check("R7 stays at zero", v, 32'h0);

    // R8 clear semantics
    wr(2'd3, 0);
    rd(2'd3, v); check("R8 write zero keeps pending", v, 32'h1);
    wr(2'd3, 1);
    rd(2'd3, v); check("R8 write one clears", v, 32'h0);
    check("R9 irq drops with pending", {31'd0, irq}, 32'h0);
    ticks(2);
    rd(2'd3, v); check("R7 zero count no pending", v, 32'h0);

    // R10 clear and expiry collide
    wr(2'd0, 32'h1);
    @(negedge clk); sec_tick = 1; wr_en = 1; addr = 2'd3; wdata = 1;
    @(negedge clk); sec_tick = 0; wr_en = 0;
    rd(2'd3, v); check("R10 expiry beats clear", v, 32'h1);
    wr(2'd3, 1);

    // R11 write against tick, cancel
    wr(2'd0, 32'hA);
    @(negedge clk); sec_tick = 1; wr_en = 1; addr = 2'd0; wdata = 32'h20;
    @(negedge clk); sec_tick = 0; wr_en = 0;
    rd(2'd0, v); check("R11 write beats tick", v, 32'h20);
    wr(2'd0, 32'h0);
    ticks(3);
    rd(2'd0, v); check("R11 cancelled count", v, 32'h0);
    rd(2'd3, v); check("R11 no pending after cancel", v, 32'h0);

    // R9 interrupt enable off masks
    wr(2'd0, 32'h1);
    ticks(1);
    check("R9 irq with enable", {31'd0, irq}, 32'h1);
    wr(2'd2, 0);
    check("R9 irq masked again", {31'd0, irq}, 32'h0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    rd(2'd3, v); check("R1 reset clears pending", v, 32'h0);
    rd(2'd1, v); check("R1 reset clears run enable", v, 32'h0);

    done = 1;
    finish_run();
  end
endmodule